// File: doc/BRIEF.md
# JTAG Word Shift Engine

This block drives a JTAG port from words that software has already buffered. Each 32-bit word written to the block carries two parallel 16-bit streams. The low half goes out on TDI and the high half goes out on TMS, one bit of each per TCK period. Writing words does not start any activity. Software can preload up to eight words and then issue a separate start pulse. From that point the engine pops words back to back until the transmit buffer runs dry. It then stops, and TCK stays low until the next start.

While shifting, the engine samples TDO on every rising TCK edge and packs 16 samples into a receive word. It pushes that word into an eight-entry receive buffer, which software drains through a show-ahead read port. If the receive buffer is full when a word completes, the word is discarded, a sticky overrun flag is raised, and shifting carries on. TCK is derived from the system clock by a divider. The divider setting gives the number of system cycles in each TCK half period, so one word costs 32 times that setting. For example, a setting of 10 at 100 MHz gives a 5 MHz TCK and 320 cycles per word.

Top module: `jtag_shift_engine`

## Requirements
- R1: A write with `wr_en` high pushes `wr_data` as one transmit entry. Bits 15:0 are sent on TDI and bits 31:16 on TMS, bit k of each half in the same TCK period.
- R2: A write while the transmit buffer holds 8 entries is discarded, and the buffered contents are unchanged.
- R3: Writing words never starts shifting. `busy` stays 0 and TCK stays low until a `start` pulse arrives.
- R4: Each buffer holds 8 words. `tx_full` rises after 8 unsent writes, and `rx_full` rises after 8 unread received words.
- R5: Words are sent back to back with no idle TCK between them, including words written during a transfer. When the transmit buffer is empty at a word's final falling TCK edge, `busy` drops at that edge and TCK stays low until the next start.
- R6: A received word that completes while the receive buffer is full is dropped and the buffered words are kept. Shifting continues, and `rx_ovf` is set and stays set until an `ovf_clr` pulse.
- R7: Each TCK half period lasts `half_period` system cycles, with 0 treated as 1. A word takes 32·`half_period` cycles from start to `busy` low.
- R8: Bits are sent least-significant first: bit 0 of each half is on TDI/TMS at the word's first rising TCK edge.
- R9: TDI and TMS change only at falling TCK edges. TDO is sampled at each rising edge and the first sample lands in bit 0 of the received word. `rd_data` shows the oldest received word, and `rd_en` removes it.
- R10: A `start` pulse while the transmit buffer is empty is ignored: `busy` stays 0 and no TCK edge appears.
- R11: After reset both buffers are empty, and `busy`, `tck`, `tdi`, `tms` and `rx_ovf` are 0.
- R12: `tx_empty`, `tx_full`, `rx_empty` and `rx_full` follow the buffer occupancy after every write, transfer and read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Push `wr_data` into the transmit buffer |
| wr_data | input | 32 | {TMS bits, TDI bits} for 16 TCK periods |
| start | input | 1 | Begin shifting buffered words |
| rd_en | input | 1 | Remove the oldest received word |
| rd_data | output | 16 | Oldest received word (show-ahead) |
| half_period | input | 8 | System cycles per TCK half period |
| ovf_clr | input | 1 | Clear the receive overrun flag |
| tx_full | output | 1 | Transmit buffer full |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive buffer full |
| rx_empty | output | 1 | Receive buffer empty |
| busy | output | 1 | Engine shifting |
| rx_ovf | output | 1 | Sticky receive overrun flag |
| tck | output | 1 | JTAG clock |
| tdi | output | 1 | JTAG data out |
| tms | output | 1 | JTAG mode select |
| tdo | input | 1 | JTAG data in |

## Verification
The bench sweeps the divider over 0, 1, 2, 3 and 5, together with one-, two- and three-word bursts. A divider off by one, or a transfer that idles between words, shows up in the exact busy cycle count. TDO is looped back as TDI xor TMS, with optional inversion, so any bit-order reversal or capture on the wrong edge corrupts both the bits recorded at TCK rises and the received words. The buffer boundaries are tested directly. A ninth write that is not discarded becomes a ninth shifted word. A received word that overwrites stored data, or an overrun that halts shifting or fails to raise the sticky flag, changes what is read back. A start on an empty buffer that is not ignored produces TCK edges.

// File: rtl/jse_pkg.sv
package jse_pkg;
    typedef enum logic {
        ENG_IDLE  = 1'b0,
        ENG_SHIFT = 1'b1
    } eng_state_e;
endpackage

// File: rtl/jse_fifo.sv
module jse_fifo #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] wdata,
    input  logic             pop,
    output logic [WIDTH-1:0] rdata,
    output logic             full,
    output logic             empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [DEPTH-1:0][WIDTH-1:0] mem;
        logic [AW-1:0]               wptr;
        logic [AW-1:0]               rptr;
        logic [CW-1:0]               cnt;
    } fifo_st_t;

    fifo_st_t q, d;
    logic do_push, do_pop;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    always_comb begin
        d       = q;
        do_push = push && (q.cnt != CW'(DEPTH));
        do_pop  = pop && (q.cnt != '0);
        if (do_push) begin
            d.mem[q.wptr] = wdata;
            d.wptr        = ptr_inc(q.wptr);
        end
        if (do_pop) begin
            d.rptr = ptr_inc(q.rptr);
        end
        d.cnt = q.cnt + CW'(do_push) - CW'(do_pop);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rdata = q.mem[q.rptr];
    assign full  = (q.cnt == CW'(DEPTH));
    assign empty = (q.cnt == '0);

    AST_FIFO_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        push && full && !pop |=> full && $stable(q.wptr)) else $error("full push accepted"); // R2
    AST_FIFO_CNT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
        q.cnt <= CW'(DEPTH)) else $error("count beyond depth"); // R4
    AST_FIFO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop && empty && !push |=> empty) else $error("pop of empty buffer"); // R12
endmodule

// File: rtl/jse_tck_gen.sv
module jse_tck_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_period,
    output logic             tck,
    output logic             rise_stb,
    output logic             fall_stb
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             tck;
    } div_st_t;

    div_st_t q, d;
    logic [DIV_W-1:0] limit;
    logic             wrap;

    always_comb begin
        limit    = (half_period == '0) ? DIV_W'(1) : half_period;
        wrap     = run && (q.cnt >= limit - DIV_W'(1));
        rise_stb = wrap && !q.tck;
        fall_stb = wrap && q.tck;
        d        = q;
        if (!run) begin
            d.cnt = '0;
            d.tck = 1'b0;
        end else if (wrap) begin
            d.cnt = '0;
            d.tck = !q.tck;
        end else begin
            d.cnt = q.cnt + DIV_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tck = q.tck;

    AST_TCK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> !tck) else $error("tck toggles while stopped"); // R5
    AST_TCK_RISE_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> tck) else $error("rise strobe without high tck"); // R7
    AST_TCK_FALL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
        fall_stb |=> !tck) else $error("fall strobe without low tck"); // R7
endmodule

// File: rtl/jse_shifter.sv
module jse_shifter
    import jse_pkg::*;
#(
    parameter int HALF_W = 16
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                tx_empty,
    input  logic [2*HALF_W-1:0] tx_word,
    input  logic                rx_full,
    input  logic                tdo,
    input  logic                rise_stb,
    input  logic                fall_stb,
    input  logic                ovf_clr,
    output logic                tx_pop,
    output logic                rx_push,
    output logic [HALF_W-1:0]   rx_word,
    output logic                tdi,
    output logic                tms,
    output logic                busy,
    output logic                rx_ovf
);
    localparam int BW = $clog2(HALF_W);

    typedef struct packed {
        eng_state_e        st;
        logic [HALF_W-1:0] tdi_sr;
        logic [HALF_W-1:0] tms_sr;
        logic [HALF_W-1:0] cap_sr;
        logic [BW-1:0]     bit_idx;
        logic              ovf;
    } shf_st_t;

    shf_st_t q, d;
    logic    last_bit;

    always_comb begin
        d        = q;
        tx_pop   = 1'b0;
        rx_push  = 1'b0;
        rx_word  = q.cap_sr;
        last_bit = (q.bit_idx == BW'(HALF_W - 1));
        unique case (q.st)
            ENG_IDLE: begin
                if (start && !tx_empty) begin
                    tx_pop    = 1'b1;
                    d.tdi_sr  = tx_word[HALF_W-1:0];
                    d.tms_sr  = tx_word[2*HALF_W-1:HALF_W];
                    d.bit_idx = '0;
                    d.st      = ENG_SHIFT;
                end
            end
            ENG_SHIFT: begin
                if (rise_stb) begin
                    d.cap_sr = {tdo, q.cap_sr[HALF_W-1:1]};
                end
                if (fall_stb) begin
                    if (last_bit) begin
                        rx_push   = 1'b1;
                        d.bit_idx = '0;
                        if (!tx_empty) begin
                            tx_pop   = 1'b1;
                            d.tdi_sr = tx_word[HALF_W-1:0];
                            d.tms_sr = tx_word[2*HALF_W-1:HALF_W];
                        end else begin
                            d.st = ENG_IDLE;
                        end
                    end else begin
                        d.tdi_sr  = q.tdi_sr >> 1;
                        d.tms_sr  = q.tms_sr >> 1;
                        d.bit_idx = q.bit_idx + BW'(1);
                    end
                end
            end
            default: d.st = ENG_IDLE;
        endcase
        if (ovf_clr) d.ovf = 1'b0;
        if (rx_push && rx_full) d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign busy   = (q.st == ENG_SHIFT);
    assign tdi    = busy && q.tdi_sr[0];
    assign tms    = busy && q.tms_sr[0];
    assign rx_ovf = q.ovf;

    AST_START_EMPTY_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && start && tx_empty |=> !busy) else $error("start on empty buffer"); // R10
    AST_OVF_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push && rx_full |=> rx_ovf) else $error("drop without overrun flag"); // R6
    AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ovf && !ovf_clr |=> rx_ovf) else $error("overrun flag lost"); // R6
    AST_DATA_HOLD_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        rise_stb |=> $stable(tdi) && $stable(tms)) else $error("data moved at rising edge"); // R9
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_stb && fall_stb)) else $error("both tck strobes"); // R7
endmodule

// File: rtl/jtag_shift_engine.sv
module jtag_shift_engine #(
    parameter int HALF_W     = 16,
    parameter int FIFO_DEPTH = 8,
    parameter int DIV_W      = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [2*HALF_W-1:0] wr_data,
    input  logic                start,
    input  logic                rd_en,
    output logic [HALF_W-1:0]   rd_data,
    input  logic [DIV_W-1:0]    half_period,
    input  logic                ovf_clr,
    output logic                tx_full,
    output logic                tx_empty,
    output logic                rx_full,
    output logic                rx_empty,
    output logic                busy,
    output logic                rx_ovf,
    output logic                tck,
    output logic                tdi,
    output logic                tms,
    input  logic                tdo
);
    localparam int TX_W = 2 * HALF_W;

    logic              tx_pop, rx_push, rise_stb, fall_stb;
    logic [TX_W-1:0]   tx_word;
    logic [HALF_W-1:0] rx_word;

    jse_fifo #(.WIDTH(TX_W), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(wr_en), .wdata(wr_data), .pop(tx_pop),
        .rdata(tx_word), .full(tx_full), .empty(tx_empty)
    );

    jse_fifo #(.WIDTH(HALF_W), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_word), .pop(rd_en),
        .rdata(rd_data), .full(rx_full), .empty(rx_empty)
    );

    jse_tck_gen #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .half_period(half_period),
        .tck(tck), .rise_stb(rise_stb), .fall_stb(fall_stb)
    );

    jse_shifter #(.HALF_W(HALF_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .start(start), .tx_empty(tx_empty), .tx_word(tx_word),
        .rx_full(rx_full), .tdo(tdo), .rise_stb(rise_stb), .fall_stb(fall_stb),
        .ovf_clr(ovf_clr), .tx_pop(tx_pop), .rx_push(rx_push), .rx_word(rx_word),
        .tdi(tdi), .tms(tms), .busy(busy), .rx_ovf(rx_ovf)
    );

    AST_TCK_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !tck) else $error("tck high while idle"); // R5
    AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> !tx_empty) else $error("pop of empty transmit buffer"); // R5
endmodule

// File: tb/sim_jtag_shift_engine.sv
module sim_jtag_shift_engine;
    localparam int HW = 16;
    localparam int DEPTH = 8;
    localparam int DW = 8;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic          rst_n, wr_en, start, rd_en, ovf_clr, tdo_inv;
    logic [2*HW-1:0] wr_data;
    logic [HW-1:0] rd_data;
    logic [DW-1:0] half_period;
    logic tx_full, tx_empty, rx_full, rx_empty, busy, rx_ovf, tck, tdi, tms, tdo;

    assign tdo = tdi ^ tms ^ tdo_inv;

    jtag_shift_engine #(.HALF_W(HW), .FIFO_DEPTH(DEPTH), .DIV_W(DW)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .start(start),
        .rd_en(rd_en), .rd_data(rd_data), .half_period(half_period), .ovf_clr(ovf_clr),
        .tx_full(tx_full), .tx_empty(tx_empty), .rx_full(rx_full), .rx_empty(rx_empty),
        .busy(busy), .rx_ovf(rx_ovf), .tck(tck), .tdi(tdi), .tms(tms), .tdo(tdo)
    );

    int   rise_total = 0;
    logic cap_tdi [0:4095];
    logic cap_tms [0:4095];
    always @(posedge tck) begin
        if (rise_total < 4096) begin
            cap_tdi[rise_total] = tdi;
            cap_tms[rise_total] = tms;
        end
        rise_total = rise_total + 1;
    end

    int n_chk = 0;
    int n_bad = 0;
    logic [31:0] ws [0:15];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] v);
        @(negedge clk); wr_en = 1'b1; wr_data = v;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd(output logic [HW-1:0] v);
        @(negedge clk); v = rd_data; rd_en = 1'b1;
        @(negedge clk); rd_en = 1'b0;
    endtask

    task automatic run_measure(output int cyc);
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        cyc = 0;
        while (busy && cyc < 20000) begin
            cyc++;
            @(negedge clk);
        end
    endtask

    task automatic verify_bits(input int base, input int nw);
        for (int j = 0; j < nw; j++) begin
            logic [HW-1:0] gi, gm;
            for (int k = 0; k < HW; k++) begin
                gi[k] = cap_tdi[base + HW*j + k];
                gm[k] = cap_tms[base + HW*j + k];
            end
            chk(gi == ws[j][15:0], "R8", "tdi bits lsb first", gi, ws[j][15:0]);
            chk(gm == ws[j][31:16], "R1", "tms bits", gm, ws[j][31:16]);
        end
    endtask

    task automatic verify_rx(input int nw, input logic inv);
        for (int j = 0; j < nw; j++) begin
            logic [HW-1:0] got, exp;
            exp = ws[j][15:0] ^ ws[j][31:16] ^ {HW{inv}};
            rd(got);
            chk(got == exp, "R9", "captured tdo word", got, exp);
        end
        chk(rx_empty, "R12", "rx empty after reads", rx_empty, 1);
    endtask

    function automatic logic [31:0] mkword(input int run, input int j);
        logic [31:0] m;
        m = 32'h9E37_79B9 * 32'(run * 16 + j + 1);
        return m ^ 32'h5A5A_0F0F;
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cyc, base, run;
        logic [HW-1:0] dummy;
        int divs [0:3];
        divs[0] = 1; divs[1] = 2; divs[2] = 3; divs[3] = 5;
        rst_n = 1'b0; wr_en = 1'b0; start = 1'b0; rd_en = 1'b0; ovf_clr = 1'b0;
        tdo_inv = 1'b0; wr_data = '0; half_period = 8'd1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        chk(tx_empty && rx_empty && !tx_full && !rx_full && !busy && !tck && !tdi && !tms && !rx_ovf,
            "R11", "reset state", {tx_empty, rx_empty, tx_full, rx_full, busy, tck, tdi, tms, rx_ovf},
            9'b110000000);

        // R10 start on empty buffer
        base = rise_total;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        repeat (20) @(negedge clk);
        chk(!busy && rise_total == base, "R10", "start on empty ignored", rise_total - base, 0);

        // sweep divider, burst length and tdo polarity
        run = 0;
        for (int di = 0; di < 4; di++) begin
            for (int inv = 0; inv < 2; inv++) begin
                int n, nw;
                n  = divs[di];
                nw = 1 + (run % 3);
                half_period = DW'(n);
                tdo_inv = inv[0];
                for (int j = 0; j < nw; j++) ws[j] = mkword(run, j);
                base = rise_total;
                for (int j = 0; j < nw; j++) wr(ws[j]);
                chk(!tx_empty && !tx_full, "R12", "tx flags after writes", {tx_empty, tx_full}, 2'b00);
                repeat (2*n + 5) @(negedge clk);
                chk(!busy && rise_total == base && !tck, "R3", "writes do not start", rise_total - base, 0);
                run_measure(cyc);
                chk(cyc == 32*n*nw, "R7", "busy cycles", cyc, 32*n*nw);
                chk(rise_total - base == HW*nw, "R5", "tck rises", rise_total - base, HW*nw);
                verify_bits(base, nw);
                repeat (3*n + 5) @(negedge clk);
                chk(rise_total - base == HW*nw && !tck, "R5", "tck frozen after underrun",
                    rise_total - base, HW*nw);
                chk(tx_empty && !rx_empty, "R12", "flags after transfer", {tx_empty, rx_empty}, 2'b10);
                verify_rx(nw, inv[0]);
                run++;
            end
        end

        // R7 divider value 0 behaves as 1
        half_period = 8'd0; tdo_inv = 1'b0;
        ws[0] = mkword(40, 0);
        wr(ws[0]);
        run_measure(cyc);
        chk(cyc == 32, "R7", "zero divider", cyc, 32);
        verify_rx(1, 1'b0);

        // R4/R2 full transmit buffer, R6 receive overrun
        half_period = 8'd1;
        for (int j = 0; j < 9; j++) ws[j] = mkword(50, j);
        base = rise_total;
        for (int j = 0; j < 8; j++) wr(ws[j]);
        chk(tx_full, "R4", "tx full after 8 writes", tx_full, 1);
        wr(ws[8]);
        chk(tx_full, "R2", "tx still full after extra write", tx_full, 1);
        run_measure(cyc);
        chk(rise_total - base == 128, "R2", "extra write discarded", rise_total - base, 128);
        chk(cyc == 256, "R5", "eight words back to back", cyc, 256);
        verify_bits(base, 8);
        chk(rx_full && !rx_ovf, "R4", "rx full after 8 words", {rx_full, rx_ovf}, 2'b10);
        base = rise_total;
        wr(mkword(60, 0));
        run_measure(cyc);
        chk(cyc == 32 && rise_total - base == 16, "R6", "shifting continues on overrun", cyc, 32);
        chk(rx_ovf, "R6", "overrun flag set", rx_ovf, 1);
        repeat (5) @(negedge clk);
        chk(rx_ovf, "R6", "overrun flag sticky", rx_ovf, 1);
        @(negedge clk); ovf_clr = 1'b1;
        @(negedge clk); ovf_clr = 1'b0;
        chk(!rx_ovf, "R6", "overrun flag cleared", rx_ovf, 0);
        verify_rx(8, 1'b0);

        // R5 word written during a transfer follows with no gap
        half_period = 8'd2;
        ws[0] = mkword(70, 0); ws[1] = mkword(70, 1);
        base = rise_total;
        wr(ws[0]);
        fork
            begin
                repeat (8) @(negedge clk);
                wr(ws[1]);
            end
        join_none
        run_measure(cyc);
        chk(cyc == 128, "R5", "late write appended without gap", cyc, 128);
        verify_bits(base, 2);
        verify_rx(2, 1'b0);
        rd(dummy);
        chk(rx_empty, "R12", "read of empty rx harmless", rx_empty, 1);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule